// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a memory-mapped watchdog peripheral. Software programs a reload constant, sets a sticky enable bit and then services the timer by writing a two-value key to a dedicated service register: first 0xAA, then 0x55. Only that exact pair reloads the down-counter. Between services the counter drops by one every four clock cycles, through a fixed divide-by-four prescaler. When it passes zero, the block latches an expiry flag and a wake flag. The wake flag drives the interrupt line. If the reset-on-expiry option is set, the block also emits a fixed-length system reset pulse.

A broken key, meaning any value other than 0x55 written right after 0xAA, is treated as a fault. It produces the same reset pulse, provided the reset option is on. Once the enable bit is set, software cannot clear it. The wake flag also ignores software. Only the block's own reset returns either bit to zero. A write to any other register between the two key values cancels the half-entered key quietly.

The bus is a single-cycle register port with a write strobe, a byte address and 32-bit write data. Read data is combinational from the current address.

Top module: `keyfed_wdt`

## Requirements
- R1: After reset the control register reads 0, the reload constant reads 0xFF, the counter reads 0xFF, and both irq and sys_rst are low.
- R2: Control register at offset 0x00 holds these bits: bit 0 enable, bit 1 reset-on-expiry, bit 2 expiry flag, bit 3 wake flag. Writing 0 to bit 0 never clears an enable that is already set.
- R3: The reload constant at offset 0x04 is 31 bits wide. Bit 31 of a write is dropped. A written value below 0xFF is stored as 0xFF.
- R4: The counter at offset 0x0C holds its value until the first good key after enable. Key writes made while enable is 0 have no effect.
- R5: Writing 0xAA and then 0x55 to offset 0x08 loads the counter from the reload constant. After that the counter decreases by one every 4 clocks.
- R6: When the counter is 0 and one more 4-clock step elapses, the expiry flag and the wake flag are both set. The counter reloads and keeps running, and irq follows the wake flag.
- R7: Writing 1 to bit 2 of the control register clears the expiry flag. Bit 3 ignores all writes and stays set until block reset.
- R8: On expiry with bit 1 set, sys_rst is high for exactly 16 consecutive clocks. With bit 1 clear, sys_rst stays low.
- R9: Writing a value other than 0x55 directly after 0xAA does not reload the counter. If bit 1 is set, it produces the 16-clock sys_rst pulse.
- R10: A write to any address other than 0x08 between 0xAA and 0x55 cancels the key. The following 0x55 then neither reloads the counter nor causes a reset.
- R11: Reads of offset 0x08 and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Wake interrupt level |
| sys_rst | output | 1 | System reset pulse |

## Verification
The in-line assertions cover the invariants that hold on every cycle:
- the enable and wake bits are sticky;
- the reload constant never drops below its floor;
- the counter moves only by one step or by a reload;
- a key never reloads and faults in the same cycle;
- each pulse start is followed by an active pulse.

Other properties only show up in the bench scenarios, which run against a behavioural model compared every clock. These are the exact expiry cycle, the 16-cycle pulse width, the clamp on the reload constant, key cancellation by an intervening write, and keys being ignored while the block is disabled.

// File: rtl/keyfed_wdt_pkg.sv
package keyfed_wdt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'hC;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef struct packed {
    logic wake;
    logic expired;
    logic rst_on_exp;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/keyfed_wdt_key.sv
module keyfed_wdt_key
  import keyfed_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic       is_key_i,
  input  logic [7:0] data_i,
  output logic       reload_o,
  output logic       fault_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d  = armed_q;
    reload_o = 1'b0;
    fault_o  = 1'b0;
    if (wr_i) begin
      if (!is_key_i) begin
        armed_d = 1'b0;
      end else if (en_i) begin
        if (armed_q) begin
          armed_d = 1'b0;
          if (data_i == KEY_SECOND) reload_o = 1'b1;
          else                      fault_o  = 1'b1;
        end else if (data_i == KEY_FIRST) begin
          armed_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R9
  key_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reload_o, fault_o}));
endmodule

// File: rtl/keyfed_wdt_count.sv
module keyfed_wdt_count #(
  parameter int CNT_W   = 31,
  parameter int PRE_W   = 2,
  parameter int RST_VAL = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o
);
  logic             run_q, run_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step        = run_q && (pre_q == '1);
  assign underflow_o = step && (cnt_q == '0) && !reload_i;
  assign cnt_o       = cnt_q;

  always_comb begin
    run_d = run_q;
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (reload_i) begin
      run_d = 1'b1;
      pre_d = '0;
      cnt_d = load_val_i;
    end else if (run_q) begin
      pre_d = pre_q + 1'b1;
      if (step) cnt_d = (cnt_q == '0) ? load_val_i : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= CNT_W'(RST_VAL);
    end else begin
      run_q <= run_d;
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !reload_i && cnt_q != '0) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/keyfed_wdt_pulse.sv
module keyfed_wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (start_i)            left_d = LW'(LEN);
    else if (left_q != '0)  left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign active_o = (left_q != '0);

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o);
  // R8
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !start_i) |=> !active_o);
endmodule

// File: rtl/keyfed_wdt.sv
module keyfed_wdt
  import keyfed_wdt_pkg::*;
#(
  parameter int CNT_W     = 31,
  parameter int PRE_W     = 2,
  parameter int PULSE_LEN = 16,
  parameter int MIN_LOAD  = 255
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq,
  output logic                 sys_rst
);
  localparam logic [CNT_W-1:0] LOAD_FLOOR = CNT_W'(MIN_LOAD);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wr_load;
  logic [3:0]       ctrl_bits;
  logic             wr_ctrl, wr_load_en, is_key;
  logic             reload, fault, underflow, pulse_go;

  assign is_key     = (bus_addr == OFS_KEY);
  assign wr_ctrl    = bus_we && (bus_addr == OFS_CTRL);
  assign wr_load_en = bus_we && (bus_addr == OFS_LOAD);
  assign wr_load    = bus_wdata[CNT_W-1:0];

  keyfed_wdt_key u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (ctrl_q.enable),
    .wr_i     (bus_we),
    .is_key_i (is_key),
    .data_i   (bus_wdata[7:0]),
    .reload_o (reload),
    .fault_o  (fault)
  );

  keyfed_wdt_count #(.CNT_W(CNT_W), .PRE_W(PRE_W), .RST_VAL(MIN_LOAD)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .reload_i    (reload),
    .load_val_i  (load_q),
    .cnt_o       (cnt),
    .underflow_o (underflow)
  );

  assign pulse_go = (underflow || fault) && ctrl_q.rst_on_exp;

  keyfed_wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (pulse_go),
    .active_o (sys_rst)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.enable     = ctrl_q.enable | bus_wdata[0];
      ctrl_d.rst_on_exp = bus_wdata[1];
      if (bus_wdata[2]) ctrl_d.expired = 1'b0;
    end
    if (underflow) begin
      ctrl_d.expired = 1'b1;
      ctrl_d.wake    = 1'b1;
    end
  end

  always_comb begin
    load_d = load_q;
    if (wr_load_en) load_d = (wr_load < LOAD_FLOOR) ? LOAD_FLOOR : wr_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= LOAD_FLOOR;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
    end
  end

  assign ctrl_bits = ctrl_q;
  assign irq       = ctrl_q.wake;

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = {{(DATA_W-4){1'b0}}, ctrl_bits};
      OFS_LOAD: bus_rdata = DATA_W'(load_q);
      OFS_CNT:  bus_rdata = DATA_W'(cnt);
      default:  bus_rdata = '0;
    endcase
  end

  // R2
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.enable |=> ctrl_q.enable);
  // R7
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.wake |=> ctrl_q.wake);
  // R3
  load_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_q >= LOAD_FLOOR);
  // R6
  expiry_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (irq && ctrl_q.expired));
endmodule

// File: tb/keyfed_wdt_bench.sv
module keyfed_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sys_rst;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyfed_wdt u_keyfed_wdt (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sys_rst(sys_rst)
  );

  // behavioural reference model
  bit m_en, m_rsto, m_exp, m_wake, m_run, m_armed;
  longint m_load, m_cnt;
  int m_pre, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_rsto = 0; m_exp = 0; m_wake = 0; m_run = 0; m_armed = 0;
      m_load = 255; m_cnt = 255; m_pre = 0; m_pulse = 0;
    end else begin
      bit reload, fault, under, rsto_old;
      reload = 0; fault = 0;
      rsto_old = m_rsto;
      if (bus_we) begin
        if (bus_addr != 4'h8) m_armed = 0;
        else if (m_en) begin
          if (m_armed) begin
            m_armed = 0;
            if (bus_wdata[7:0] == 8'h55) reload = 1; else fault = 1;
          end else if (bus_wdata[7:0] == 8'hAA) m_armed = 1;
        end
      end
      under = m_run && (m_pre == 3) && (m_cnt == 0) && !reload;
      if (reload) begin
        m_cnt = m_load; m_pre = 0; m_run = 1;
      end else if (m_run) begin
        if (m_pre == 3) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
        m_pre = (m_pre + 1) % 4;
      end
      if (bus_we && bus_addr == 4'h0) begin
        if (bus_wdata[0]) m_en = 1;
        m_rsto = bus_wdata[1];
        if (bus_wdata[2]) m_exp = 0;
      end
      if (under) begin m_exp = 1; m_wake = 1; end
      if (bus_we && bus_addr == 4'h4) begin
        m_load = bus_wdata[30:0];
        if (m_load < 255) m_load = 255;
      end
      if ((under || fault) && rsto_old) m_pulse = 16;
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
    end
  end

  function automatic longint model_rd(logic [3:0] a);
    case (a)
      4'h0: return {m_wake, m_exp, m_rsto, m_en};
      4'h4: return m_load;
      4'hC: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model: R5 R6 R8 R9 R10
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 irq model", irq, m_wake);
      check("R8 sys_rst model", sys_rst, m_pulse != 0);
      check("R5 rdata model", bus_rdata, model_rd(bus_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse_len(string req, int exp);
    int n, guard;
    n = 0; guard = 0;
    while (!sys_rst && guard < 3000) begin @(negedge clk); guard++; end
    while (sys_rst && n < 100) begin n++; @(negedge clk); end
    check(req, n, exp);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    idle(1);
    rd(4'h0, v); check("R1 ctrl", v, 0);
    rd(4'h4, v); check("R1 load", v, 32'hFF);
    rd(4'hC, v); check("R1 cnt", v, 32'hFF);
    check("R1 irq", irq, 0);
    check("R1 sys_rst", sys_rst, 0);
    rd(4'h8, v); check("R11 key read", v, 0);
    rd(4'h2, v); check("R11 unmapped read", v, 0);

    wr(4'h4, 32'h10);       rd(4'h4, v); check("R3 floor", v, 32'hFF);
    wr(4'h4, 32'hFFFF_FF00); rd(4'h4, v); check("R3 bit31 dropped", v, 32'h7FFF_FF00);
    wr(4'h4, 32'h100);      rd(4'h4, v); check("R3 plain", v, 32'h100);

    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    rd(4'hC, v); check("R4 key while disabled", v, 32'hFF);
    wr(4'h0, 32'h1); idle(20);
    rd(4'hC, v); check("R4 idle after enable", v, 32'hFF);

    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    rd(4'hC, v); check("R5 reload", v, 32'h100);
    idle(40);
    rd(4'hC, v); check("R5 counting", v, 32'h100 - 10);

    wr(4'h0, 32'h0);
    rd(4'h0, v); check("R2 enable sticky", v[0], 1);

    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    check("R6 irq raised", irq, 1);
    rd(4'h0, v); check("R6 flags", v, 32'hD);
    check("R8 no pulse when bit1 clear", sys_rst, 0);

    wr(4'h0, 32'h5); rd(4'h0, v); check("R7 expiry cleared", v, 32'h9);
    wr(4'h0, 32'h0); rd(4'h0, v); check("R7 wake stays", v, 32'h9);

    wr(4'h0, 32'h2);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    pulse_len("R8 pulse width", 16);

    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    idle(400);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h12);
    rd(4'hC, v); check("R9 no reload", v < 32'h100 - 50, 1);
    pulse_len("R9 fault pulse", 16);

    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    idle(400);
    wr(4'h8, 32'hAA); wr(4'h4, 32'h100); wr(4'h8, 32'h55);
    rd(4'hC, v); check("R10 cancelled key", v < 32'h100 - 50, 1);
    idle(20);
    check("R10 no reset", sys_rst, 0);

    idle(5);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule